// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is the descriptor engine of a bus-master DMA channel. Software places a table of 8-byte region descriptors in memory and hands the engine the table's base address with a start pulse. The engine reads each descriptor as two dwords over a simple memory read port. The dword at the descriptor pointer is the region's byte address. The dword at pointer + 4 carries the byte count in bits 15:0 and the end-of-table flag in bit 31, which is bit 7 of descriptor byte 7.

For each valid region the engine asks a data mover for dword-aligned chunks of at most `BURST_BYTES` bytes. Each completion reports how many bytes were moved, and the engine subtracts that amount from the region's remaining count. Once the region marked last is exhausted the walk ends. Malformed tables and malformed regions end the walk with an error status. A stop command ends the walk early, but only after the outstanding read or data chunk has completed.

The status output uses 0 = idle, 1 = active, 2 = done and 3 = error.

Top module: `prd_walker`

## Requirements
- R1: A start pulse while the status is idle, done or error loads the base. If the base has any nonzero bit below `TBL_BITS`, the status becomes 3 one cycle later and no read is issued. Otherwise the status becomes 1 and the first read goes to the base.
- R2: Each descriptor is fetched by a read of the dword at the pointer (the region address) and then a read of the dword at pointer + 4 (count in bits 15:0, end flag in bit 31). A read request holds its address steady until it is acknowledged, and read data is taken in the acknowledge cycle.
- R3: A count field of zero stands for 65536 bytes.
- R4: A region address with either of bits 1:0 set gives status 3, with no data request.
- R5: A region whose low 16 address bits plus its byte count exceed 65536 crosses a 64 KB boundary and gives status 3. A region that ends exactly on the boundary is accepted.
- R6: A data request carries a dword-aligned address and a length of min(remaining, `BURST_BYTES`). Address and length hold steady until the completion arrives.
- R7: Each completion lowers the remaining count and raises the request address by the reported byte count, limited to the remaining count. Requests repeat until the remaining count reaches zero. Short completions are expected to be whole dwords.
- R8: After a region that is not last, the next descriptor is read at pointer + 8. The offset below `TBL_BITS` wraps, and the upper bits stay those of the base.
- R9: When the last region is exhausted the status becomes 2 on the following cycle. It stays 2 until the next start.
- R10: A stop pulse during a walk sends the status to 0 after the outstanding read or data completion, and no further request follows. A stop pulse while idle, done or error has no effect.
- R11: A start pulse during an active walk is ignored.
- R12: After reset the status is 0 and no read or data request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples base_i |
| stop_i | input | 1 | Stop pulse |
| base_i | input | ADDR_W | Descriptor table base address |
| mrd_req_o | output | 1 | Descriptor read request |
| mrd_addr_o | output | ADDR_W | Descriptor read dword address |
| mrd_ack_i | input | 1 | Read acknowledge, with data valid |
| mrd_data_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Data chunk request to the mover |
| xfer_addr_o | output | ADDR_W | Chunk start byte address |
| xfer_len_o | output | LEN_W | Chunk length in bytes |
| xfer_done_i | input | 1 | Chunk completion |
| xfer_bytes_i | input | LEN_W | Bytes moved by this completion |
| status_o | output | 2 | 0 idle, 1 active, 2 done, 3 error |

## Verification
The bench builds the walker with `TBL_BITS` = 6. The table window is then 64 bytes, so pointer wrap-around shows up after eight descriptors, and base-alignment errors show up in the low six bits. `BURST_BYTES` = 64 keeps a full 65536-byte region to 1024 chunks, which makes the zero-count case affordable. With chunks this short, the last chunk of a region is often partial, and short completions from the mover occur often.

// File: rtl/prdw_pkg.sv
package prdw_pkg;

    // Region window fixed by the descriptor layout (16-bit count field).
    localparam int WIN_BITS = 16;
    localparam int CNT_BITS = WIN_BITS + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_MOVE,
        ST_DONE,
        ST_ERR
    } walk_st_e;

    typedef enum logic [1:0] {
        STAT_IDLE   = 2'd0,
        STAT_ACTIVE = 2'd1,
        STAT_DONE   = 2'd2,
        STAT_ERR    = 2'd3
    } walk_stat_e;

endpackage

// File: rtl/prdw_decode.sv
module prdw_decode
    import prdw_pkg::*;
(
    input  logic [31:0]         addr_w,
    input  logic [31:0]         hdr_w,
    output logic [CNT_BITS-1:0] bytes_o,
    output logic                last_o,
    output logic                bad_align_o,
    output logic                bad_cross_o
);

    logic [CNT_BITS:0] span_end;
    logic              unused_hdr;

    always_comb begin
        if (hdr_w[WIN_BITS-1:0] == '0) begin
            bytes_o = CNT_BITS'(1) << WIN_BITS;
        end else begin
            bytes_o = {1'b0, hdr_w[WIN_BITS-1:0]};
        end
        last_o      = hdr_w[31];
        bad_align_o = (addr_w[1:0] != 2'b00);
        span_end    = {2'b00, addr_w[WIN_BITS-1:0]} + {1'b0, bytes_o};
        bad_cross_o = (span_end > ((CNT_BITS + 1)'(1) << WIN_BITS));
    end

    assign unused_hdr = ^hdr_w[30:WIN_BITS];

endmodule

// File: rtl/prdw_beat.sv
module prdw_beat
    import prdw_pkg::*;
#(
    parameter int BURST_BYTES = 64,
    parameter int LEN_W       = $clog2(BURST_BYTES) + 1
) (
    input  logic [CNT_BITS-1:0] rem_i,
    input  logic [LEN_W-1:0]    rep_i,
    output logic [LEN_W-1:0]    len_o,
    output logic [CNT_BITS-1:0] grant_o
);

    localparam logic [CNT_BITS-1:0] BURST_C = CNT_BITS'(BURST_BYTES);

    logic [CNT_BITS-1:0] rep_ext;

    always_comb begin
        rep_ext = CNT_BITS'(rep_i);
        if (rem_i >= BURST_C) begin
            len_o = LEN_W'(BURST_BYTES);
        end else begin
            len_o = rem_i[LEN_W-1:0];
        end
        grant_o = (rep_ext > rem_i) ? rem_i : rep_ext;
    end

endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prdw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int TBL_BITS    = 16,
    parameter int BURST_BYTES = 64,
    parameter int LEN_W       = $clog2(BURST_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mrd_req_o,
    output logic [ADDR_W-1:0] mrd_addr_o,
    input  logic              mrd_ack_i,
    input  logic [31:0]       mrd_data_i,
    output logic              xfer_req_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [LEN_W-1:0]  xfer_len_o,
    input  logic              xfer_done_i,
    input  logic [LEN_W-1:0]  xfer_bytes_i,
    output logic [1:0]        status_o
);

    typedef struct packed {
        walk_st_e            st;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   cur;
        logic [CNT_BITS-1:0] rem;
        logic                last;
        logic                stop_pend;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [CNT_BITS-1:0] dec_bytes;
    logic                dec_last, dec_bad_align, dec_bad_cross;
    logic [CNT_BITS-1:0] beat_grant;
    logic [CNT_BITS-1:0] rem_after;
    logic [TBL_BITS-1:0] next_off;
    logic                stop_now;

    prdw_decode u_decode (
        .addr_w      (walk_q.cur[31:0]),
        .hdr_w       (mrd_data_i),
        .bytes_o     (dec_bytes),
        .last_o      (dec_last),
        .bad_align_o (dec_bad_align),
        .bad_cross_o (dec_bad_cross)
    );

    prdw_beat #(
        .BURST_BYTES (BURST_BYTES),
        .LEN_W       (LEN_W)
    ) u_beat (
        .rem_i   (walk_q.rem),
        .rep_i   (xfer_bytes_i),
        .len_o   (xfer_len_o),
        .grant_o (beat_grant)
    );

    always_comb begin
        walk_d    = walk_q;
        stop_now  = walk_q.stop_pend | stop_i;
        rem_after = walk_q.rem - beat_grant;
        next_off  = walk_q.ptr[TBL_BITS-1:0] + TBL_BITS'(8);

        case (walk_q.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start_i) begin
                    walk_d.stop_pend = 1'b0;
                    walk_d.ptr       = base_i;
                    if (base_i[TBL_BITS-1:0] != '0) begin
                        walk_d.st = ST_ERR;
                    end else begin
                        walk_d.st = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: begin
                if (mrd_ack_i) begin
                    walk_d.cur = ADDR_W'(mrd_data_i);
                    walk_d.st  = stop_now ? ST_IDLE : ST_RD_HI;
                end else begin
                    walk_d.stop_pend = stop_now;
                end
            end
            ST_RD_HI: begin
                if (mrd_ack_i) begin
                    if (stop_now) begin
                        walk_d.st = ST_IDLE;
                    end else if (dec_bad_align || dec_bad_cross) begin
                        walk_d.st = ST_ERR;
                    end else begin
                        walk_d.rem  = dec_bytes;
                        walk_d.last = dec_last;
                        walk_d.st   = ST_MOVE;
                    end
                end else begin
                    walk_d.stop_pend = stop_now;
                end
            end
            ST_MOVE: begin
                if (xfer_done_i) begin
                    walk_d.rem = rem_after;
                    walk_d.cur = walk_q.cur + ADDR_W'(beat_grant);
                    if (stop_now) begin
                        walk_d.st = ST_IDLE;
                    end else if (rem_after == '0) begin
                        if (walk_q.last) begin
                            walk_d.st = ST_DONE;
                        end else begin
                            walk_d.ptr = {walk_q.ptr[ADDR_W-1:TBL_BITS], next_off};
                            walk_d.st  = ST_RD_LO;
                        end
                    end
                end else begin
                    walk_d.stop_pend = stop_now;
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign mrd_req_o   = (walk_q.st == ST_RD_LO) || (walk_q.st == ST_RD_HI);
    assign mrd_addr_o  = {walk_q.ptr[ADDR_W-1:3], (walk_q.st == ST_RD_HI), 2'b00};
    assign xfer_req_o  = (walk_q.st == ST_MOVE);
    assign xfer_addr_o = walk_q.cur;

    always_comb begin
        case (walk_q.st)
            ST_IDLE:  status_o = STAT_IDLE;
            ST_DONE:  status_o = STAT_DONE;
            ST_ERR:   status_o = STAT_ERR;
            default:  status_o = STAT_ACTIVE;
        endcase
    end

endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 64,
    parameter int LEN_W       = $clog2(BURST_BYTES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mrd_req_o,
    input logic [ADDR_W-1:0] mrd_addr_o,
    input logic              mrd_ack_i,
    input logic              xfer_req_o,
    input logic [ADDR_W-1:0] xfer_addr_o,
    input logic [LEN_W-1:0]  xfer_len_o,
    input logic              xfer_done_i,
    input logic [1:0]        status_o
);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd0) |-> (!mrd_req_o && !xfer_req_o));

    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req_o && !mrd_ack_i) |=> (mrd_req_o && $stable(mrd_addr_o)));

    a_r2_rd_dword: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req_o |-> (mrd_addr_o[1:0] == 2'b00));

    a_r6_req_shape: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_addr_o[1:0] == 2'b00 && xfer_len_o != '0
                        && xfer_len_o <= LEN_W'(BURST_BYTES)));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_done_i) |=>
        (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o)));

    a_r2_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_req_o && xfer_req_o));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd2 && !start_i) |=> (status_o == 2'd2));

    a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd3) |-> (!mrd_req_o && !xfer_req_o));

endmodule

bind prd_walker prd_walker_chk #(
    .ADDR_W      (ADDR_W),
    .BURST_BYTES (BURST_BYTES),
    .LEN_W       (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mrd_req_o   (mrd_req_o),
    .mrd_addr_o  (mrd_addr_o),
    .mrd_ack_i   (mrd_ack_i),
    .xfer_req_o  (xfer_req_o),
    .xfer_addr_o (xfer_addr_o),
    .xfer_len_o  (xfer_len_o),
    .xfer_done_i (xfer_done_i),
    .status_o    (status_o)
);

// File: tb/prd_walker_test.sv
`timescale 1ns/1ps
module prd_walker_test;

    localparam int ADDR_W = 32;
    localparam int TBL    = 6;
    localparam int BURST  = 64;
    localparam int LEN_W  = 7;
    localparam logic [31:0] TMASK = (32'd1 << TBL) - 32'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, stop_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic              mrd_req_o, mrd_ack_i = 1'b0;
    logic [ADDR_W-1:0] mrd_addr_o;
    logic [31:0]       mrd_data_i = '0;
    logic              xfer_req_o, xfer_done_i = 1'b0;
    logic [ADDR_W-1:0] xfer_addr_o;
    logic [LEN_W-1:0]  xfer_len_o, xfer_bytes_i = '0;
    logic [1:0]        status_o;

    int tests = 0, fails = 0;
    logic [31:0] mem [bit [31:0]];

    always #2.5 clk = ~clk;

    prd_walker #(.ADDR_W(ADDR_W), .TBL_BITS(TBL), .BURST_BYTES(BURST), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .base_i(base_i),
        .mrd_req_o(mrd_req_o), .mrd_addr_o(mrd_addr_o), .mrd_ack_i(mrd_ack_i),
        .mrd_data_i(mrd_data_i), .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o),
        .xfer_len_o(xfer_len_o), .xfer_done_i(xfer_done_i), .xfer_bytes_i(xfer_bytes_i),
        .status_o(status_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic bit region_bad(input logic [31:0] a, input int cnt);
        return (a[1:0] != 2'b00) || (int'(a[15:0]) + cnt > 65536);
    endfunction

    task automatic put_desc(input logic [31:0] p, input logic [31:0] a,
                            input logic [15:0] c, input bit eot);
        mem[p]     = a;
        mem[p + 4] = {eot, 15'h0, c};
    endtask

    // Runs one walk from base; mirrors the expected sequence from the requirements.
    task automatic walk(input logic [31:0] base, input int stop_beat, input int patch_fetch,
                        input int ign_cyc, input string tag,
                        output logic [1:0] fin, output int moved);
        logic [31:0] ptr, cur, a, w1;
        int rem, cnt, beats, fetches, blen, bytes, phase;
        bit last, stopping, fin_seen;
        logic [1:0] expst;
        ptr = base; phase = 0; beats = 0; fetches = 0; moved = 0;
        stopping = 0; fin_seen = 0; expst = 2'd1; rem = 0; cur = '0; a = '0; last = 0;
        start_i = 1'b1; base_i = base;
        @(negedge clk);
        start_i = 1'b0;
        check(status_o == 2'd1, "R1 active after start", status_o, 1);
        for (int cyc = 0; cyc < 40000 && !fin_seen; cyc++) begin
            mrd_ack_i = 1'b0; xfer_done_i = 1'b0; xfer_bytes_i = '0; stop_i = 1'b0; start_i = 1'b0;
            if (cyc == ign_cyc) begin
                start_i = 1'b1; base_i = 32'h0000_0007; // R11: bad base, must be ignored
            end
            if (phase < 2) begin
                check(mrd_req_o && mrd_addr_o == ptr + (phase == 1 ? 32'd4 : 32'd0),
                      "R2/R8 read address", mrd_addr_o, ptr + (phase == 1 ? 32'd4 : 32'd0));
                if ($urandom % 3 != 0) begin
                    mrd_ack_i = 1'b1;
                    if (phase == 0) begin
                        a = mem_rd(ptr); mrd_data_i = a; phase = 1;
                    end else begin
                        w1 = mem_rd(ptr + 4); mrd_data_i = w1; fetches++;
                        if (fetches == patch_fetch) mem[base + 4] = mem[base + 4] | 32'h8000_0000;
                        cnt  = (w1[15:0] == 16'h0) ? 65536 : int'(w1[15:0]);
                        last = w1[31];
                        if (stopping) begin
                            expst = 2'd0; fin_seen = 1;
                        end else if (region_bad(a, cnt)) begin
                            expst = 2'd3; fin_seen = 1;
                        end else begin
                            phase = 2; cur = a; rem = cnt;
                        end
                    end
                end
            end else begin
                blen = (rem > BURST) ? BURST : rem;
                check(xfer_req_o && xfer_addr_o == cur && int'(xfer_len_o) == blen,
                      "R6/R7 data request", (longint'(xfer_addr_o) << 8) | xfer_len_o,
                      (longint'(cur) << 8) | blen);
                if (beats == stop_beat && !stopping) begin
                    stop_i = 1'b1; stopping = 1;
                end else if ($urandom % 3 != 0) begin
                    bytes = blen;
                    if (blen >= 8 && blen % 4 == 0 && $urandom % 4 == 0)
                        bytes = 4 * (1 + int'($urandom % (blen / 4 - 1)));
                    xfer_done_i = 1'b1; xfer_bytes_i = LEN_W'(bytes);
                    rem -= bytes; cur += bytes; moved += bytes; beats++;
                    if (stopping) begin
                        expst = 2'd0; fin_seen = 1;
                    end else if (rem == 0) begin
                        if (last) begin
                            expst = 2'd2; fin_seen = 1;
                        end else begin
                            ptr = (ptr & ~TMASK) | ((ptr + 32'd8) & TMASK);
                            phase = 0;
                        end
                    end
                end
            end
            @(negedge clk);
        end
        mrd_ack_i = 1'b0; xfer_done_i = 1'b0; stop_i = 1'b0; start_i = 1'b0;
        check(fin_seen, "walk did not finish", 0, 1);
        check(status_o == expst && !mrd_req_o && !xfer_req_o, tag, status_o, expst);
        fin = status_o;
    endtask

    initial begin
        #(200000 * 5);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [1:0] fin;
        int moved;
        logic [31:0] base;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R12: reset state
        check(status_o == 2'd0 && !mrd_req_o && !xfer_req_o, "R12 reset state", status_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(status_o == 2'd0, "R12 idle after reset", status_o, 0);

        // R1: misaligned base
        start_i = 1'b1; base_i = 32'h1000_0020;
        @(negedge clk);
        start_i = 1'b0;
        check(status_o == 2'd3 && !mrd_req_o, "R1 bad base error", status_o, 3);

        // R2 R6 R9: single short region
        mem.delete();
        put_desc(32'h2000_0040, 32'h0001_0100, 16'd12, 1'b1);
        walk(32'h2000_0040, -1, -1, -1, "R9 single region done", fin, moved);
        check(moved == 12, "R7 bytes moved single", moved, 12);
        // R10: stop while done has no effect
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        repeat (2) @(negedge clk);
        check(status_o == 2'd2 && !mrd_req_o, "R10 stop ignored when done", status_o, 2);

        // R3: zero count is 65536 bytes
        mem.delete();
        put_desc(32'h3000_0000, 32'h0005_0000, 16'h0000, 1'b1);
        walk(32'h3000_0000, -1, -1, -1, "R3 full window done", fin, moved);
        check(moved == 65536, "R3 zero count length", moved, 65536);

        // R4: misaligned region address
        mem.delete();
        put_desc(32'h3000_0080, 32'h0001_0002, 16'd8, 1'b1);
        walk(32'h3000_0080, -1, -1, -1, "R4 unaligned region error", fin, moved);
        check(fin == 2'd3 && moved == 0, "R4 no data moved", moved, 0);

        // R5: crossing and exact boundary
        mem.delete();
        put_desc(32'h3000_00C0, 32'h0002_FFF0, 16'h0014, 1'b1);
        walk(32'h3000_00C0, -1, -1, -1, "R5 crossing error", fin, moved);
        check(fin == 2'd3, "R5 crossing status", fin, 3);
        put_desc(32'h3000_00C0, 32'h0002_FFF0, 16'h0010, 1'b1);
        walk(32'h3000_00C0, -1, -1, -1, "R5 exact boundary accepted", fin, moved);
        check(fin == 2'd2 && moved == 16, "R5 boundary moved", moved, 16);

        // R8: pointer wrap within the table window
        mem.delete();
        for (int i = 0; i < 8; i++)
            put_desc(32'h4000_0000 + 32'(8 * i), 32'h0007_0000 + 32'(256 * i), 16'd20, 1'b0);
        walk(32'h4000_0000, -1, 8, -1, "R8 wrap then done", fin, moved);
        check(moved == 9 * 20, "R8 regions after wrap", moved, 9 * 20);

        // R10: stop mid-region
        mem.delete();
        put_desc(32'h5000_0000, 32'h0008_0000, 16'd1000, 1'b1);
        walk(32'h5000_0000, 3, -1, -1, "R10 stop to idle", fin, moved);
        repeat (3) @(negedge clk);
        check(status_o == 2'd0 && !mrd_req_o && !xfer_req_o, "R10 quiet after stop", status_o, 0);

        // R11: start during walk ignored
        mem.delete();
        put_desc(32'h5000_0040, 32'h0009_0000, 16'd100, 1'b0);
        put_desc(32'h5000_0048, 32'h0009_1000, 16'd30, 1'b1);
        walk(32'h5000_0040, -1, -1, 4, "R11 walk unaffected", fin, moved);
        check(moved == 130, "R11 total moved", moved, 130);

        // Random tables
        for (int t = 0; t < 25; t++) begin
            int nd;
            logic [31:0] ra;
            int rc;
            int total;
            mem.delete();
            base = $urandom & ~TMASK;
            nd = 1 + int'($urandom % 4);
            total = 0;
            for (int i = 0; i < nd; i++) begin
                ra = $urandom & 32'hFFFF_FFFC;
                rc = 1 + int'($urandom % 400);
                if (int'(ra[15:0]) + rc > 65536) ra[15:0] = ra[15:0] & 16'h7FFC;
                total += rc;
                put_desc(base + 32'(8 * i), ra, 16'(rc), i == nd - 1);
            end
            walk(base, -1, -1, -1, "R9 random table done", fin, moved);
            check(moved == total, "R7 random total", moved, total);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule